// File: doc/BRIEF.md
# Radix-4 on-the-fly result converter

This block assembles the result of a combined radix-4 divide and square-root engine, taking one signed digit per iteration from the selection logic. It keeps two registered copies of the partial result. `u_o` holds the result itself. `um_o` holds the result minus one unit of the last position that has been filled. Because both forms are always ready, a negative digit never starts a carry or borrow chain. The next value of each form comes from the other one plus a small multiple of the current position's weight.

The position being filled is tracked by a thermometer mask `c_o`. The mask is refilled from the top with ones, two bits per digit. The pair of bits that has just turned on gives the weight of the current digit, so no digit counter is needed. A start pulse loads the start values for the chosen mode, and each busy cycle consumes `COPIES` digits through an unrolled chain. Digit selection, the residual datapath and rounding belong to other blocks.

All values are fixed point with `FRAC_W` fraction bits. `u_o` and `um_o` have one integer bit.

Top module: `r4otf_conv`

## Requirements
- R1: Each 4-bit digit field is one-hot signed: 1000 = +2, 0100 = +1, 0000 = 0, 0010 = -1, 0001 = -2.
- R2: A start in square-root mode (`sqrt_i`=1) loads `u_o` with bit FRAC_W set and all others clear (1.0), `um_o` with zero, and `c_o` with its two top bits set and the rest clear.
- R3: A start in division mode (`sqrt_i`=0) loads `u_o` with zero, `um_o` with bit FRAC_W set and all others clear (-1.0), and `c_o` with all zeros.
- R4: Every digit shifts `c_o` right by two places, with ones entering at the top. After n digits, `c_o` holds ones in its top 2+2n bits (square root) or its top 2n bits (division), capped at the full width.
- R5: In square-root mode, the j-th digit has weight 4^-j. After any number of digits, all FRAC_W+1 bits of `u_o` equal 1 + sum of digit times weight, modulo 2.
- R6: In division mode, the j-th digit has weight 4^(1-j). The FRAC_W fraction bits of `u_o` equal the sum of digit times weight, modulo 1.
- R7: `um_o` equals `u_o` minus the weight of the last filled position. This holds over all bits in square-root mode and over the fraction bits in division mode. Right after a start, that weight is 1.0.
- R8: One busy cycle consumes `COPIES` digits. Field i of `digits_i` (bits 4i+3..4i) is applied before field i+1.
- R9: With `start_i` and `busy_i` both low, `u_o`, `um_o` and `c_o` hold their values whatever `digits_i` carries.
- R10: `start_i` takes priority over `busy_i`. When both are high, the start values of R2/R3 are loaded and the digits are ignored.
- R11: A synchronous active-high `rst` clears `u_o`, `um_o` and `c_o` to zero.
- R12: Once `c_o` is all ones, a zero digit leaves `u_o` and `um_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load the start values for the selected mode |
| busy_i | input | 1 | Consume COPIES digits this cycle |
| sqrt_i | input | 1 | Mode at start: 1 square root, 0 division |
| digits_i | input | 4*COPIES | One-hot signed digits, field 0 first |
| u_o | output | FRAC_W+1 | Partial result |
| um_o | output | FRAC_W+1 | Partial result minus one last-place unit |
| c_o | output | FRAC_W+2 | Thermometer position mask |

## Verification
Loading start values and stepping the recurrence can be requested in the same cycle when `start_i` and `busy_i` are both high. The bench raises both together with random digit fields on the bus, then checks that all three outputs equal the start values for the chosen mode and that no digit has been folded in. A pause with only random digits present must leave every output frozen, and the operation then resumes. Both cases are judged against an independent weighted sum of the digits, kept as a 64-bit integer.

// File: rtl/r4otf_pkg.sv
package r4otf_pkg;
  // One-hot signed digit codes
  localparam logic [3:0] DIG_P2 = 4'b1000;
  localparam logic [3:0] DIG_P1 = 4'b0100;
  localparam logic [3:0] DIG_Z  = 4'b0000;
  localparam logic [3:0] DIG_M1 = 4'b0010;
  localparam logic [3:0] DIG_M2 = 4'b0001;
  localparam int unsigned DIG_W = 4;
endpackage

// File: rtl/r4otf_step.sv
// One digit of the converter: mask shift, weight extraction, U/UM update.
module r4otf_step
  import r4otf_pkg::*;
#(
  parameter int FRAC_W = 16,
  localparam int C_W = FRAC_W + 2,
  localparam int U_W = FRAC_W + 1
) (
  input  logic [DIG_W-1:0] dig_i,
  input  logic [C_W-1:0]   c_i,
  input  logic [U_W-1:0]   u_i,
  input  logic [U_W-1:0]   um_i,
  output logic [C_W-1:0]   c_o,
  output logic [U_W-1:0]   u_o,
  output logic [U_W-1:0]   um_o
);
  logic [C_W-1:0] fresh, lowest;
  logic [U_W-1:0] w1, w2, w3;

  always_comb begin
    c_o    = {2'b11, c_i[C_W-1:2]};
    fresh  = c_o & ~c_i;               // pair switched on by this shift
    lowest = fresh & ~(fresh << 1);    // lower bit of that pair
    w1     = lowest[U_W-1:0];
    w2     = w1 << 1;
    w3     = w1 + w2;
  end

  always_comb begin
    unique case (dig_i)
      DIG_P2:  begin u_o = u_i + w2;  um_o = u_i + w1;  end
      DIG_P1:  begin u_o = u_i + w1;  um_o = u_i;       end
      DIG_M1:  begin u_o = um_i + w3; um_o = um_i + w2; end
      DIG_M2:  begin u_o = um_i + w2; um_o = um_i + w1; end
      default: begin u_o = u_i;       um_o = um_i + w3; end
    endcase
  end

  // R4/R5: at most one weight bit is ever selected
  always_comb begin
    p_weight_onehot_r5: assert ($onehot0(w1));
  end
endmodule

// File: rtl/r4otf_chain.sv
// COPIES unrolled digit steps evaluated in one cycle.
module r4otf_chain
  import r4otf_pkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int COPIES = 2,
  localparam int C_W = FRAC_W + 2,
  localparam int U_W = FRAC_W + 1
) (
  input  logic [COPIES*DIG_W-1:0] digits_i,
  input  logic [C_W-1:0]          c_i,
  input  logic [U_W-1:0]          u_i,
  input  logic [U_W-1:0]          um_i,
  output logic [C_W-1:0]          c_o,
  output logic [U_W-1:0]          u_o,
  output logic [U_W-1:0]          um_o
);
  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    logic [C_W-1:0] c_in, c_out;
    logic [U_W-1:0] u_in, um_in, u_out, um_out;
    if (i == 0) begin : g_head
      assign c_in  = c_i;
      assign u_in  = u_i;
      assign um_in = um_i;
    end else begin : g_link
      assign c_in  = g_copy[i-1].c_out;
      assign u_in  = g_copy[i-1].u_out;
      assign um_in = g_copy[i-1].um_out;
    end
    r4otf_step #(.FRAC_W(FRAC_W)) u_step (
      .dig_i (digits_i[i*DIG_W +: DIG_W]),
      .c_i   (c_in),
      .u_i   (u_in),
      .um_i  (um_in),
      .c_o   (c_out),
      .u_o   (u_out),
      .um_o  (um_out)
    );
  end

  assign c_o  = g_copy[COPIES-1].c_out;
  assign u_o  = g_copy[COPIES-1].u_out;
  assign um_o = g_copy[COPIES-1].um_out;
endmodule

// File: rtl/r4otf_conv.sv
// Registered result pair and position mask with start/step control.
module r4otf_conv
  import r4otf_pkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int COPIES = 2,
  localparam int C_W = FRAC_W + 2,
  localparam int U_W = FRAC_W + 1,
  localparam int SH  = 2 * COPIES
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    busy_i,
  input  logic                    sqrt_i,
  input  logic [COPIES*DIG_W-1:0] digits_i,
  output logic [U_W-1:0]          u_o,
  output logic [U_W-1:0]          um_o,
  output logic [C_W-1:0]          c_o
);
  localparam logic [U_W-1:0] U_ONE  = {1'b1, {FRAC_W{1'b0}}};
  localparam logic [C_W-1:0] C_SQRT = {2'b11, {FRAC_W{1'b0}}};
  localparam logic [C_W-1:0] C_TOP  = ~({C_W{1'b1}} >> SH);

  logic [C_W-1:0] c_nx;
  logic [U_W-1:0] u_nx, um_nx;

  r4otf_chain #(.FRAC_W(FRAC_W), .COPIES(COPIES)) u_chain (
    .digits_i (digits_i),
    .c_i      (c_o),
    .u_i      (u_o),
    .um_i     (um_o),
    .c_o      (c_nx),
    .u_o      (u_nx),
    .um_o     (um_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      u_o  <= '0;
      um_o <= '0;
      c_o  <= '0;
    end else if (start_i) begin
      u_o  <= sqrt_i ? U_ONE : '0;
      um_o <= sqrt_i ? '0 : U_ONE;
      c_o  <= sqrt_i ? C_SQRT : '0;
    end else if (busy_i) begin
      u_o  <= u_nx;
      um_o <= um_nx;
      c_o  <= c_nx;
    end
  end

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (u_o == '0 && um_o == '0 && c_o == '0));

  p_init_sqrt_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && sqrt_i) |=> (u_o == U_ONE && um_o == '0 && c_o == C_SQRT));

  p_init_div_r3: assert property (@(posedge clk) disable iff (rst)
    (start_i && !sqrt_i) |=> (u_o == '0 && um_o == U_ONE && c_o == '0));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !busy_i) |=> ($stable(u_o) && $stable(um_o) && $stable(c_o)));

  p_mask_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !start_i) |=> (c_o == (($past(c_o) >> SH) | C_TOP)));

  p_mask_therm_r4: assert property (@(posedge clk) disable iff (rst)
    ((c_o << 1) & ~c_o) == '0);
endmodule

// File: tb/r4otf_conv_bench.sv
`timescale 1ns/1ps
module r4otf_conv_bench;
  localparam int FW = 16;
  localparam int CP = 2;
  localparam int CW = FW + 2;
  localparam int UW = FW + 1;

  logic clk = 1'b0;
  logic rst, start_i, busy_i, sqrt_i;
  logic [CP*4-1:0] digits_i;
  logic [UW-1:0] u_o, um_o;
  logic [CW-1:0] c_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  longint ref_u, last_w;
  int nshift;
  bit mode_s;

  always #2.5 clk = ~clk;

  r4otf_conv #(.FRAC_W(FW), .COPIES(CP)) u_r4otf_conv (
    .clk, .rst, .start_i, .busy_i, .sqrt_i, .digits_i, .u_o, .um_o, .c_o
  );

  // R1 digit code
  function automatic logic [3:0] enc(int q);
    case (q)
      2:  return 4'b1000;
      1:  return 4'b0100;
      -1: return 4'b0010;
      -2: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [CW-1:0] therm(int k);
    if (k >= CW) return {CW{1'b1}};
    return ~({CW{1'b1}} >> k);
  endfunction

  function automatic int pick(int pat, int j);
    case (pat)
      1: return 2;
      2: return -2;
      3: return 0;
      4: return (j % 2) ? 1 : -1;
      default: return int'($urandom_range(0, 4)) - 2;
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    longint mask;
    mask = mode_s ? ((longint'(1) << UW) - 1) : ((longint'(1) << FW) - 1);
    chk({tag, " u"},  longint'(u_o) & mask, ref_u & mask);
    chk({tag, " um"}, longint'(um_o) & mask, (ref_u - last_w) & mask);
    chk({tag, " c R4"}, longint'(c_o), longint'(therm(mode_s ? 2 + 2*nshift : 2*nshift)));
  endtask

  task automatic op(bit s, int pat, bit pause, bit co_busy);
    int ndig, ncyc;
    @(negedge clk);
    start_i = 1'b1; sqrt_i = s; busy_i = co_busy; digits_i = CP*4'($urandom);
    @(posedge clk); @(negedge clk);
    start_i = 1'b0; busy_i = 1'b0;
    mode_s = s; nshift = 0; last_w = longint'(1) << FW;
    ref_u = s ? (longint'(1) << FW) : 0;
    if (co_busy) check_state("R10 start over busy");
    else check_state(s ? "R2 sqrt init" : "R3 div init");
    ndig = s ? FW/2 : FW/2 + 1;
    ncyc = (ndig + CP - 1) / CP;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      logic [CP*4-1:0] vec;
      for (int i = 0; i < CP; i++) begin
        int j, q;
        longint w;
        j = cyc*CP + i + 1;
        q = (j <= ndig) ? pick(pat, j) : 0;
        vec[i*4 +: 4] = enc(q);
        nshift++;
        if (j <= ndig) begin
          w = s ? (longint'(1) << (FW - 2*j)) : (longint'(1) << (FW - 2*(j-1)));
          ref_u += q * w;
          last_w = w;
        end
      end
      busy_i = 1'b1; digits_i = vec;
      @(posedge clk); @(negedge clk);
      busy_i = 1'b0;
      if (!s && cyc == ncyc-1) check_state("R12 R6 R7 R8 R1 div tail");
      else check_state(s ? "R5 R7 R8 R1 sqrt" : "R6 R7 R8 R1 div");
      if (pause && cyc == 0) begin
        digits_i = CP*4'($urandom);
        @(posedge clk); @(negedge clk);
        check_state("R9 idle hold");
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start_i = 1'b0; busy_i = 1'b0; sqrt_i = 1'b0; digits_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset u", longint'(u_o), 0);
    chk("R11 reset um", longint'(um_o), 0);
    chk("R11 reset c", longint'(c_o), 0);
    op(1, 1, 0, 0);
    op(1, 2, 0, 0);
    op(0, 1, 0, 0);
    op(0, 2, 0, 0);
    op(1, 3, 0, 0);
    op(0, 3, 0, 0);
    op(0, 4, 1, 0);
    op(1, 4, 1, 1);
    op(0, 0, 1, 1);
    for (int k = 0; k < 40; k++)
      op(1'($urandom), 0, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
    // R11: reset in the middle of an operation
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    chk("R11 mid reset u", longint'(u_o), 0);
    chk("R11 mid reset um", longint'(um_o), 0);
    chk("R11 mid reset c", longint'(c_o), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule